// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and Gated Shared Interrupt

This block is a bank of sixteen general-purpose pins that sit behind a small register bus. Software sets each pin's drive direction. It updates the output levels with a single masked write, so one pin can be changed without a read-modify-write sequence. It reads back the synchronized input levels and selects which of the upper eight pins may contribute to a common interrupt line.

The lower eight pins leave the bank as individual raw level requests for an external interrupt controller. The upper eight pins are each gated by an enable bit and then merged into one active-high request. A control register holds two separate bits, one for soft reset and one for clock enable. Writing reset-plus-clock and then clock alone brings the bank into service. Writing reset alone parks the bank in a low-power state.

Pin inputs pass through a two-stage synchronizer before they are used. While the clock enable is off, the captured pin state freezes and the shared request stays low.

Top module: `gpio_bank`

## Requirements
- R1: After `rst`, the direction, output and interrupt-enable registers are zero, `pin_oe`, `pin_out` and `shared_req` are low, and the control register reads 2 (soft reset held, clock off).
- R2: Offset 0x00 is the direction register; bit n = 1 makes pin n an output. The register reads back as written, and `pin_oe` follows it.
- R3: A write to offset 0x08 sets output bit n to data bit n only when mask bit n+16 of the write data is 1. Bits whose mask bit is 0 keep their value. Offset 0x08 reads back the output register, and `pin_out` follows it.
- R4: Offset 0x0C returns the captured pin levels in bits 15:0, with bits 31:16 zero. A pin change reaches the captured state on the third rising edge after it is applied.
- R5: `shared_req` is high one cycle after the captured state shows some pin k in 8..15 high with its enable set, and it is low otherwise.
- R6: With parameter `HI_EN_AT_LOW` = 0, pins 8..15 are enabled by interrupt-enable bits 15:8 (offset 0x10). With `HI_EN_AT_LOW` = 1, they are enabled by bits 7:0, and pin 8+i maps to bit i. The unused half has no effect on the request.
- R7: `lo_req[i]` equals the captured level of pin i for i in 0..7, with no enable gating.
- R8: Offset 0x14 is the control register: bit 0 is the clock enable and bit 1 is the soft reset. Writes to it always take effect, and it reads back in bits 1:0.
- R9: While the soft-reset bit is 1, the direction, output and interrupt-enable registers are cleared, and writes to them are ignored.
- R10: While the clock enable is 0, the captured pin state (readback and `lo_req`) holds, and `shared_req` is low.
- R11: A read returns its data on `bus_rdata` one cycle after the request. Offsets not listed above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output levels to the pads |
| pin_oe | output | 16 | Per-pin output enable (1 = drive) |
| lo_req | output | 8 | Raw level requests of pins 0..7 |
| shared_req | output | 1 | Combined gated request of pins 8..15 |

## Verification
The embedded assertions watch four behaviours on every cycle:
- a masked output write never disturbs an unmasked bit;
- the soft reset leaves the writable registers at zero;
- with the clock gated off, the captured state stays frozen and the shared line stays low;
- an empty enable set, or an unmapped read, yields zero.

Only the bench scenarios can show the rest:
- the actual values landed by masked writes;
- the three-edge pin latency;
- the two enable-bit layouts, side by side;
- the full bring-up sequence of writing 3 and then 1, and the state that resumes after the clock is ungated.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_AW = 5;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFF_DIR = 5'h00;
  localparam logic [BUS_AW-1:0] OFF_OUT = 5'h08;
  localparam logic [BUS_AW-1:0] OFF_PIN = 5'h0C;
  localparam logic [BUS_AW-1:0] OFF_IEN = 5'h10;
  localparam logic [BUS_AW-1:0] OFF_CTL = 5'h14;

  localparam int unsigned CTL_CLKEN = 0;
  localparam int unsigned CTL_SRST  = 1;
  localparam logic [1:0]  CTL_RESET_VAL = 2'b10;

  function automatic logic is_mapped(input logic [BUS_AW-1:0] a);
    return (a == OFF_DIR) || (a == OFF_OUT) || (a == OFF_PIN) ||
           (a == OFF_IEN) || (a == OFF_CTL);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_state,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   out_q,
  output logic [NPIN-1:0]   ie_q,
  output logic [1:0]        ctl_q
);
  localparam int unsigned PAD = BUS_DW - NPIN;

  logic            wr_en;
  logic            rd_en;
  logic [NPIN-1:0] wmask;
  logic [NPIN-1:0] wval;
  logic [BUS_DW-1:0] rd_mux;

  assign wr_en = bus_req && bus_wr;
  assign rd_en = bus_req && !bus_wr;
  assign wmask = bus_wdata[16 +: NPIN];
  assign wval  = bus_wdata[NPIN-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      out_q <= '0;
      ie_q  <= '0;
      ctl_q <= CTL_RESET_VAL;
    end else begin
      if (wr_en && bus_addr == OFF_CTL) ctl_q <= bus_wdata[1:0];
      if (ctl_q[CTL_SRST]) begin
        dir_q <= '0;
        out_q <= '0;
        ie_q  <= '0;
      end else if (wr_en) begin
        case (bus_addr)
          OFF_DIR: dir_q <= wval;
          OFF_OUT: out_q <= (out_q & ~wmask) | (wval & wmask);
          OFF_IEN: ie_q  <= wval;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_DIR: rd_mux = {{PAD{1'b0}}, dir_q};
      OFF_OUT: rd_mux = {{PAD{1'b0}}, out_q};
      OFF_PIN: rd_mux = {{PAD{1'b0}}, pin_state};
      OFF_IEN: rd_mux = {{PAD{1'b0}}, ie_q};
      OFF_CTL: rd_mux = {{(BUS_DW-2){1'b0}}, ctl_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  // R3: unmasked output bits never move on a masked write
  assert_masked_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == OFF_OUT && !ctl_q[CTL_SRST]) |=>
      (((out_q ^ $past(out_q)) & ~$past(bus_wdata[16 +: NPIN])) == '0));

  // R9: soft reset leaves the writable registers cleared
  assert_srst_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q[CTL_SRST] |=> (dir_q == '0 && out_q == '0 && ie_q == '0));

  // R11: unmapped reads return zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_mapped(bus_addr)) |=> (bus_rdata == '0));
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int unsigned NPIN         = 16,
  parameter bit          HI_EN_AT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic [NPIN-1:0]   lvl,
  input  logic [NPIN-1:0]   ie,
  output logic [NPIN-1:0]   pstate,
  output logic [NPIN/2-1:0] lo_req,
  output logic              shared_req
);
  localparam int unsigned HALF = NPIN / 2;

  logic [HALF-1:0] hi_en;

  assign hi_en = HI_EN_AT_LOW ? ie[HALF-1:0] : ie[NPIN-1:HALF];

  always_ff @(posedge clk) begin
    if (rst)         pstate <= '0;
    else if (clk_en) pstate <= lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) shared_req <= 1'b0;
    else     shared_req <= clk_en && (|(pstate[NPIN-1:HALF] & hi_en));
  end

  assign lo_req = pstate[HALF-1:0];

  // R10: clock gated off freezes the captured state
  assert_frozen_state_R10: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(pstate));

  // R10: clock gated off silences the shared request
  assert_gated_low_R10: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> !shared_req);

  // R5: no enabled upper pin means no shared request
  assert_no_enable_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (hi_en == '0) |=> !shared_req);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN         = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          HI_EN_AT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_oe,
  output logic [7:0]        lo_req,
  output logic              shared_req
);
  logic [NPIN-1:0] lvl_sync;
  logic [NPIN-1:0] pstate;
  logic [NPIN-1:0] ie_q;
  logic [1:0]      ctl_q;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (lvl_sync)
  );

  gpio_regs #(.NPIN(NPIN)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_state (pstate),
    .dir_q     (pin_oe),
    .out_q     (pin_out),
    .ie_q      (ie_q),
    .ctl_q     (ctl_q)
  );

  gpio_sense #(.NPIN(NPIN), .HI_EN_AT_LOW(HI_EN_AT_LOW)) u_sense (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (ctl_q[CTL_CLKEN]),
    .lvl        (lvl_sync),
    .ie         (ie_q),
    .pstate     (pstate),
    .lo_req     (lo_req),
    .shared_req (shared_req)
  );
endmodule

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata_a, rdata_b;
  logic [15:0] pin_in;
  logic [15:0] pout_a, poe_a, pout_b, poe_b;
  logic [7:0]  lo_a, lo_b;
  logic        sh_a, sh_b;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .pin_in(pin_in), .pin_out(pout_a), .pin_oe(poe_a),
    .lo_req(lo_a), .shared_req(sh_a)
  );

  gpio_bank #(.HI_EN_AT_LOW(1'b1)) uut_lo (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .pin_in(pin_in), .pin_out(pout_b), .pin_oe(poe_b),
    .lo_req(lo_b), .shared_req(sh_b)
  );

  // {write data, expected output register}
  localparam int VN = 7;
  localparam logic [47:0] VEC [VN] = '{
    {32'hFFFF_1234, 16'h1234},
    {32'h00FF_FFFF, 16'h12FF},
    {32'hFF00_0000, 16'h00FF},
    {32'h0000_FFFF, 16'h00FF},
    {32'h8001_FFFF, 16'h80FF},
    {32'h0F0F_A5A5, 16'h85F5},
    {32'hFFFF_0000, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = rdata_a;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state, R8 control readback
    rd(5'h14, r); chk("R1 ctl after reset", r, 32'h2);
    rd(5'h00, r); chk("R1 dir after reset", r, 32'h0);
    chk("R1 pin_oe", {16'h0, poe_a}, 32'h0);
    chk("R1 pin_out", {16'h0, pout_a}, 32'h0);
    chk("R1 shared_req", {31'h0, sh_a}, 32'h0);

    // R9 writes ignored during soft reset
    wr(5'h00, 32'h0000_FFFF);
    rd(5'h00, r); chk("R9 dir write ignored in reset", r, 32'h0);
    wr(5'h14, 32'h3);
    rd(5'h14, r); chk("R8 ctl reads 3", r, 32'h3);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, r); chk("R9 out write ignored in reset", r, 32'h0);
    wr(5'h14, 32'h1);
    rd(5'h14, r); chk("R8 ctl reads 1", r, 32'h1);

    // R2 direction
    wr(5'h00, 32'h0000_A55A);
    rd(5'h00, r); chk("R2 dir readback", r, 32'h0000_A55A);
    chk("R2 pin_oe", {16'h0, poe_a}, 32'h0000_A55A);

    // R3 masked output vectors
    for (int i = 0; i < VN; i++) begin
      wr(5'h08, VEC[i][47:16]);
      rd(5'h08, r);
      chk("R3 out readback", r, {16'h0, VEC[i][15:0]});
      chk("R3 pin_out", {16'h0, pout_a}, {16'h0, VEC[i][15:0]});
    end

    // R4 latency and readback, R7 raw low requests
    @(negedge clk); pin_in = 16'hC3A5;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R4 not yet after two edges", {24'h0, lo_a}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R4 captured on third edge", {24'h0, lo_a}, 32'hA5);
    rd(5'h0C, r); chk("R4 pin state readback", r, 32'h0000_C3A5);
    chk("R7 lo_req raw", {24'h0, lo_a}, 32'hA5);

    // R5 / R6 shared request, both layouts (pin8 high, pin10 low)
    cyc(2);
    chk("R5 no enable", {31'h0, sh_a}, 32'h0);
    wr(5'h10, 32'h0000_0100); cyc(2);
    chk("R5 pin8 enabled", {31'h0, sh_a}, 32'h1);
    chk("R6 lo layout ignores bit8", {31'h0, sh_b}, 32'h0);
    wr(5'h10, 32'h0000_0400); cyc(2);
    chk("R5 pin10 low", {31'h0, sh_a}, 32'h0);
    wr(5'h10, 32'h0000_0001); cyc(2);
    chk("R6 hi layout ignores bit0", {31'h0, sh_a}, 32'h0);
    chk("R6 lo layout bit0 is pin8", {31'h0, sh_b}, 32'h1);
    wr(5'h10, 32'h0000_0100); cyc(2);

    // R10 clock gated off
    wr(5'h14, 32'h0);
    @(negedge clk); pin_in = 16'h3C5A;
    cyc(5);
    chk("R10 lo_req frozen", {24'h0, lo_a}, 32'hA5);
    rd(5'h0C, r); chk("R10 pin state frozen", r, 32'h0000_C3A5);
    chk("R10 shared forced low", {31'h0, sh_a}, 32'h0);
    wr(5'h14, 32'h1); cyc(2);
    chk("R10 resumes after ungate", {24'h0, lo_a}, 32'h5A);

    // R11 unmapped reads
    rd(5'h04, r); chk("R11 offset 0x04", r, 32'h0);
    rd(5'h18, r); chk("R11 offset 0x18", r, 32'h0);

    // R9 soft reset clears state after use
    wr(5'h08, 32'hFFFF_BEEF);
    wr(5'h14, 32'h3); cyc(1);
    rd(5'h00, r); chk("R9 dir cleared", r, 32'h0);
    rd(5'h08, r); chk("R9 out cleared", r, 32'h0);
    chk("R9 pin_oe cleared", {16'h0, poe_a}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule